// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Unit

This unit receives up to 24 peripheral interrupt lines and turns each active line into an interrupt message for a group of local processor interrupt units. Every line has its own programmable table entry. The entry sets the vector to deliver, an arbitration priority that does not depend on the line number, a destination mask over the processors, a delivery mode, a trigger type and a mask bit. Software writes and reads the entries through a simple indexed register port. It also writes an index to a separate port to finish service of a level-triggered line.

A message can use one of two delivery modes. In broadcast-to-mask mode it goes to every processor whose bit is set in the destination mask. In lowest-priority mode it goes to exactly one processor. That processor is chosen from the masked set by comparing the task-priority values that the processors present on their inputs in the arbitration cycle. The message leaves on a valid/ready output that holds its contents steady while it waits.

Top module: `redir_unit`

## Requirements
- R1: After reset there is no message pending (`msg_valid` low). Every entry reads back as 0x0400_0000: masked, with all other fields zero.
- R2: An entry word holds the vector in bits [7:0], the priority in [11:8], the destination mask in [23:16], lowest-priority mode in bit 24, level trigger in bit 25 and mask in bit 26. Writing an entry with `cfg_we` stores these fields. The entry at `cfg_idx` reads back with all other bits zero, including destination bits at or above NUM_CPU. An index of NUM_PINS or more reads as zero.
- R3: In broadcast-to-mask mode (bit 24 = 0), the message carries the entry's vector, `msg_lowest` = 0, and `msg_dest` equal to the programmed destination mask.
- R4: In lowest-priority mode, `msg_dest` is one-hot. It selects the processor in the destination mask with the smallest `cpu_tpr` value at the arbitration cycle. Ties go to the lowest processor index.
- R5: When several lines are eligible, the entry with the numerically highest priority field is sent first. Equal priorities go to the lowest line index. `msg_src` gives the line index of the message.
- R6: A masked line produces no message. A level-triggered line that is held high while masked is sent after it is unmasked.
- R7: An edge-triggered line produces one message per rising edge, however long it stays high.
- R8: After a level-triggered line is sent, it is not sent again until its index is written to `eoi_idx` with `eoi_we`. If the line is still high at that point, it is sent again.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_vector`, `msg_dest`, `msg_lowest` and `msg_src` hold their values.
- R10: With the output idle, a line that goes active before clock edge k shows up as `msg_valid` after edge k+1. A message is consumed on an edge where `msg_valid` and `msg_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | NUM_PINS | Interrupt request lines |
| cfg_we | input | 1 | Write strobe for the table entry at `cfg_idx` |
| cfg_idx | input | IDX_W | Entry index for writes and reads |
| cfg_wdata | input | 32 | Entry word to write |
| cfg_rdata | output | 32 | Entry word at `cfg_idx` |
| eoi_we | input | 1 | End-of-service strobe |
| eoi_idx | input | IDX_W | Line whose in-service state is cleared |
| cpu_tpr | input | NUM_CPU*TPR_W | Task priority of each processor, processor 0 in the low bits |
| msg_valid | output | 1 | Message is present |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Vector being delivered |
| msg_dest | output | NUM_CPU | Processors addressed |
| msg_lowest | output | 1 | Message was resolved in lowest-priority mode |
| msg_src | output | IDX_W | Line index that produced the message |

## Verification
The hardest state to reach is one where several lines with mixed priorities are eligible in the same cycle. Reaching it also exposes that the send order is set by the programmed priorities and not by the line numbers. The bench raises three edge-triggered lines in one cycle, with the two highest priorities equal. Then it checks the captured message order. A second hard case is a level line that is held high across a mask change and across end-of-service writes. The bench covers it by keeping one line high through a sequence of unmask, idle and clear writes. It counts the messages after each step, while a behavioural model is compared against the outputs on every clock.

// File: rtl/redir_pkg.sv
package redir_pkg;

    localparam int VEC_W    = 8;
    localparam int PRIO_W   = 4;
    localparam int DEST_MAX = 8;

    // entry word layout (software visible)
    localparam int F_VEC_LSB  = 0;
    localparam int F_PRIO_LSB = 8;
    localparam int F_DEST_LSB = 16;
    localparam int F_LOW_BIT  = 24;
    localparam int F_LVL_BIT  = 25;
    localparam int F_MSK_BIT  = 26;

    typedef struct packed {
        logic                masked;
        logic                level;
        logic                lowest;
        logic [DEST_MAX-1:0] dest;
        logic [PRIO_W-1:0]   prio;
        logic [VEC_W-1:0]    vector;
    } entry_t;

    localparam entry_t ENTRY_RST = '{masked: 1'b1, level: 1'b0, lowest: 1'b0,
                                     dest: '0, prio: '0, vector: '0};

    function automatic entry_t unpack_entry(input logic [31:0] w,
                                            input logic [DEST_MAX-1:0] keep);
        entry_t e;
        e.vector = w[F_VEC_LSB +: VEC_W];
        e.prio   = w[F_PRIO_LSB +: PRIO_W];
        e.dest   = w[F_DEST_LSB +: DEST_MAX] & keep;
        e.lowest = w[F_LOW_BIT];
        e.level  = w[F_LVL_BIT];
        e.masked = w[F_MSK_BIT];
        return e;
    endfunction

    function automatic logic [31:0] pack_entry(input entry_t e);
        logic [31:0] w;
        w = '0;
        w[F_VEC_LSB +: VEC_W]     = e.vector;
        w[F_PRIO_LSB +: PRIO_W]   = e.prio;
        w[F_DEST_LSB +: DEST_MAX] = e.dest;
        w[F_LOW_BIT]              = e.lowest;
        w[F_LVL_BIT]              = e.level;
        w[F_MSK_BIT]              = e.masked;
        return w;
    endfunction

endpackage

// File: rtl/redir_table.sv
module redir_table
    import redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int NUM_CPU  = 4,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [31:0]               wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [31:0]               rd_data,
    output entry_t [NUM_PINS-1:0]     ents
);

    localparam logic [DEST_MAX-1:0] KEEP = DEST_MAX'((32'd1 << NUM_CPU) - 32'd1);

    typedef struct packed {
        entry_t [NUM_PINS-1:0] ent;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en && (int'(wr_idx) < NUM_PINS)) begin
            s_d.ent[wr_idx] = unpack_entry(wr_data, KEEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                s_q.ent[i] <= ENTRY_RST;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = (int'(rd_idx) < NUM_PINS) ? pack_entry(s_q.ent[rd_idx]) : 32'd0;
    assign ents    = s_q.ent;

endmodule

// File: rtl/redir_pending.sv
module redir_pending #(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins,
    input  logic [NUM_PINS-1:0] level_cfg,
    input  logic [NUM_PINS-1:0] grant,
    input  logic                eoi_we,
    input  logic [IDX_W-1:0]    eoi_idx,
    output logic [NUM_PINS-1:0] req
);

    typedef struct packed {
        logic [NUM_PINS-1:0] prev;   // sampled line state
        logic [NUM_PINS-1:0] pend;   // latched rising edges
        logic [NUM_PINS-1:0] insvc;  // level lines awaiting end of service
    } state_t;

    state_t s_d, s_q;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] eoi_clr;

    always_comb begin
        eoi_clr = '0;
        if (eoi_we && (int'(eoi_idx) < NUM_PINS)) begin
            eoi_clr[eoi_idx] = 1'b1;
        end
        rise       = pins & ~s_q.prev;
        s_d.prev   = pins;
        s_d.pend   = ((s_q.pend & ~grant) | rise) & ~level_cfg;
        s_d.insvc  = ((s_q.insvc & ~eoi_clr) | (grant & level_cfg)) & level_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req = (s_q.pend & ~level_cfg) | (s_q.prev & level_cfg & ~s_q.insvc);

endmodule

// File: rtl/redir_arb.sv
module redir_arb
    import redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic [NUM_PINS-1:0]   elig,
    input  entry_t [NUM_PINS-1:0] ents,
    output logic                  any,
    output logic [IDX_W-1:0]      win_idx
);

    logic [PRIO_W-1:0] best;

    // strict comparison keeps the lower index on equal priority
    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        best    = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (elig[i] && (!any || (ents[i].prio > best))) begin
                any     = 1'b1;
                win_idx = IDX_W'(i);
                best    = ents[i].prio;
            end
        end
    end

endmodule

// File: rtl/redir_lowest.sv
module redir_lowest #(
    parameter int NUM_CPU = 4,
    parameter int TPR_W   = 4
) (
    input  logic [NUM_CPU-1:0]       cand,
    input  logic [NUM_CPU*TPR_W-1:0] tpr_flat,
    output logic [NUM_CPU-1:0]       pick
);

    logic [TPR_W-1:0] tpr [NUM_CPU];
    logic [TPR_W-1:0] best;
    logic             found;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_tpr
        assign tpr[g] = tpr_flat[g*TPR_W +: TPR_W];
    end

    always_comb begin
        found = 1'b0;
        best  = '0;
        pick  = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (cand[c] && (!found || (tpr[c] < best))) begin
                found   = 1'b1;
                best    = tpr[c];
                pick    = '0;
                pick[c] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/redir_unit.sv
module redir_unit
    import redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int NUM_CPU  = 4,
    parameter int TPR_W    = 4,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       irq_pins,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [31:0]               cfg_wdata,
    output logic [31:0]               cfg_rdata,
    input  logic                      eoi_we,
    input  logic [IDX_W-1:0]          eoi_idx,
    input  logic [NUM_CPU*TPR_W-1:0]  cpu_tpr,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [VEC_W-1:0]          msg_vector,
    output logic [NUM_CPU-1:0]        msg_dest,
    output logic                      msg_lowest,
    output logic [IDX_W-1:0]          msg_src
);

    typedef struct packed {
        logic               valid;
        logic [VEC_W-1:0]   vector;
        logic [NUM_CPU-1:0] dest;
        logic               lowest;
        logic [IDX_W-1:0]   src;
    } msg_t;

    entry_t [NUM_PINS-1:0] ents;
    logic [NUM_PINS-1:0]   level_cfg;
    logic [NUM_PINS-1:0]   req;
    logic [NUM_PINS-1:0]   elig;
    logic [NUM_PINS-1:0]   grant;
    logic                  any;
    logic [IDX_W-1:0]      win_idx;
    entry_t                win_ent;
    logic [NUM_CPU-1:0]    win_dest;
    logic [NUM_CPU-1:0]    low_pick;
    logic                  load;
    msg_t                  m_d, m_q;

    redir_table #(.NUM_PINS(NUM_PINS), .NUM_CPU(NUM_CPU)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_wdata),
        .rd_idx  (cfg_idx),
        .rd_data (cfg_rdata),
        .ents    (ents)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_line
        assign level_cfg[g] = ents[g].level;
        assign elig[g]      = req[g] & ~ents[g].masked;
    end

    redir_pending #(.NUM_PINS(NUM_PINS)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (irq_pins),
        .level_cfg (level_cfg),
        .grant     (grant),
        .eoi_we    (eoi_we),
        .eoi_idx   (eoi_idx),
        .req       (req)
    );

    redir_arb #(.NUM_PINS(NUM_PINS)) u_arb (
        .elig    (elig),
        .ents    (ents),
        .any     (any),
        .win_idx (win_idx)
    );

    assign win_ent  = ents[win_idx];
    assign win_dest = NUM_CPU'(win_ent.dest);

    redir_lowest #(.NUM_CPU(NUM_CPU), .TPR_W(TPR_W)) u_low (
        .cand     (win_dest),
        .tpr_flat (cpu_tpr),
        .pick     (low_pick)
    );

    always_comb begin
        m_d   = m_q;
        grant = '0;
        load  = any && (!m_q.valid || msg_ready);
        if (m_q.valid && msg_ready) begin
            m_d.valid = 1'b0;
        end
        if (load) begin
            grant[win_idx] = 1'b1;
            m_d.valid      = 1'b1;
            m_d.vector     = win_ent.vector;
            m_d.lowest     = win_ent.lowest;
            m_d.dest       = win_ent.lowest ? low_pick : win_dest;
            m_d.src        = win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign msg_valid  = m_q.valid;
    assign msg_vector = m_q.vector;
    assign msg_dest   = m_q.dest;
    assign msg_lowest = m_q.lowest;
    assign msg_src    = m_q.src;

endmodule

// File: rtl/redir_unit_chk.sv
module redir_unit_chk #(
    parameter int NUM_PINS = 24,
    parameter int NUM_CPU  = 4,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [7:0]         msg_vector,
    input logic [NUM_CPU-1:0] msg_dest,
    input logic               msg_lowest,
    input logic [IDX_W-1:0]   msg_src
);

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !msg_valid);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)
                                       && $stable(msg_lowest) && $stable(msg_src)));

    p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_lowest) |-> $onehot0(msg_dest));

    p_src_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (int'(msg_src) < NUM_PINS));

endmodule

bind redir_unit redir_unit_chk #(.NUM_PINS(NUM_PINS), .NUM_CPU(NUM_CPU)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_vector (msg_vector),
    .msg_dest   (msg_dest),
    .msg_lowest (msg_lowest),
    .msg_src    (msg_src)
);

// File: tb/redir_unit_tb.sv
module redir_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP    = 24;
    localparam int NC    = 4;
    localparam int TW    = 4;
    localparam int IW    = $clog2(NP);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   irq_pins = '0;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     cfg_rdata;
    logic            eoi_we = 1'b0;
    logic [IW-1:0]   eoi_idx = '0;
    logic [NC*TW-1:0] cpu_tpr = '0;
    logic            msg_valid;
    logic            msg_ready = 1'b1;
    logic [7:0]      msg_vector;
    logic [NC-1:0]   msg_dest;
    logic            msg_lowest;
    logic [IW-1:0]   msg_src;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    redir_unit #(.NUM_PINS(NP), .NUM_CPU(NC), .TPR_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .eoi_we(eoi_we), .eoi_idx(eoi_idx), .cpu_tpr(cpu_tpr),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_lowest(msg_lowest), .msg_src(msg_src)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]    t_vec  [NP];
    logic [3:0]    t_prio [NP];
    logic [NC-1:0] t_dest [NP];
    bit            t_low [NP], t_lvl [NP], t_msk [NP];
    bit            m_prev [NP], m_pend [NP], m_insvc [NP];
    bit            m_valid;
    logic [7:0]    m_vec;
    logic [NC-1:0] m_dest;
    bit            m_low;
    int            m_src;

    function automatic int tpr_of(input int c);
        return int'(cpu_tpr[c*TW +: TW]);
    endfunction

    always @(posedge clk) begin : model
        int win, best;
        bit ld, g, eo, rise, rq;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                t_vec[i] = 0; t_prio[i] = 0; t_dest[i] = 0;
                t_low[i] = 0; t_lvl[i] = 0; t_msk[i] = 1;
                m_prev[i] = 0; m_pend[i] = 0; m_insvc[i] = 0;
            end
            m_valid = 0; m_vec = 0; m_dest = 0; m_low = 0; m_src = 0;
        end else begin
            win = -1;
            for (int i = 0; i < NP; i++) begin
                rq = t_lvl[i] ? (m_prev[i] && !m_insvc[i]) : m_pend[i];
                if (rq && !t_msk[i] && (win < 0 || t_prio[i] > t_prio[win])) win = i;
            end
            ld = (win >= 0) && (!m_valid || msg_ready);
            if (m_valid && msg_ready) m_valid = 0;
            if (ld) begin
                m_valid = 1; m_vec = t_vec[win]; m_low = t_low[win]; m_src = win;
                if (t_low[win]) begin
                    best = -1;
                    for (int c = 0; c < NC; c++)
                        if (t_dest[win][c] && (best < 0 || tpr_of(c) < tpr_of(best))) best = c;
                    m_dest = (best < 0) ? '0 : NC'(1 << best);
                end else begin
                    m_dest = t_dest[win];
                end
            end
            for (int i = 0; i < NP; i++) begin
                rise = irq_pins[i] && !m_prev[i];
                g    = ld && (win == i);
                eo   = eoi_we && (int'(eoi_idx) == i);
                m_pend[i]  = t_lvl[i] ? 1'b0 : ((m_pend[i] && !g) || rise);
                m_insvc[i] = t_lvl[i] ? ((m_insvc[i] && !eo) || g) : 1'b0;
                m_prev[i]  = irq_pins[i];
            end
            if (cfg_we && int'(cfg_idx) < NP) begin
                t_vec[cfg_idx]  = cfg_wdata[7:0];
                t_prio[cfg_idx] = cfg_wdata[11:8];
                t_dest[cfg_idx] = cfg_wdata[16 +: NC];
                t_low[cfg_idx]  = cfg_wdata[24];
                t_lvl[cfg_idx]  = cfg_wdata[25];
                t_msk[cfg_idx]  = cfg_wdata[26];
            end
        end
    end

    // per-clock comparison and message capture, away from the active edge
    int            cap_src  [$];
    logic [7:0]    cap_vec  [$];
    logic [NC-1:0] cap_dest [$];

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(msg_valid === m_valid, "R10", "valid vs model", msg_valid, m_valid);
            if (m_valid) begin
                check(msg_vector === m_vec, "R3", "vector vs model", msg_vector, m_vec);
                check(msg_lowest === m_low, "R3", "mode vs model", msg_lowest, m_low);
                check(msg_dest === m_dest, "R4", "dest vs model", msg_dest, m_dest);
                check(int'(msg_src) == m_src, "R5", "src vs model", msg_src, m_src);
            end
            if (msg_valid && msg_ready) begin
                cap_src.push_back(int'(msg_src));
                cap_vec.push_back(msg_vector);
                cap_dest.push_back(msg_dest);
            end
        end
        if (cycles > 20000) begin
            check(1'b0, "R10", "watchdog expired", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] enc(input logic [7:0] v, input logic [3:0] p,
                                        input logic [7:0] d, input bit lo,
                                        input bit lv, input bit mk);
        return {5'b0, mk, lv, lo, d, 4'b0, p, v};
    endfunction

    task automatic wr_entry(input int idx, input logic [31:0] w);
        step(1); cfg_we = 1; cfg_idx = IW'(idx); cfg_wdata = w;
        step(1); cfg_we = 0;
    endtask

    task automatic rd_check(input int idx, input logic [31:0] exp, input string tag);
        step(1); cfg_idx = IW'(idx);
        @(negedge clk);
        check(cfg_rdata === exp, tag, $sformatf("entry %0d readback", idx), cfg_rdata, exp);
    endtask

    task automatic do_eoi(input int idx);
        step(1); eoi_we = 1; eoi_idx = IW'(idx);
        step(1); eoi_we = 0;
    endtask

    task automatic set_tpr(input int c, input int v);
        cpu_tpr[c*TW +: TW] = TW'(v);
    endtask

    task automatic expect_cap(input int k, input int src, input logic [7:0] vec,
                              input logic [NC-1:0] dest, input string tag);
        if (cap_src.size() <= k) begin
            check(1'b0, tag, "message missing, count", cap_src.size(), k + 1);
        end else begin
            check(cap_src[k] == src, tag, "captured src", cap_src[k], src);
            check(cap_vec[k] === vec, tag, "captured vector", cap_vec[k], vec);
            check(cap_dest[k] === dest, tag, "captured dest", cap_dest[k], dest);
        end
    endtask

    task automatic expect_count(input int n, input string tag);
        check(cap_src.size() == n, tag, "message count", cap_src.size(), n);
    endtask

    task automatic clear_cap();
        cap_src.delete(); cap_vec.delete(); cap_dest.delete();
    endtask

    // ---------------- test sequence ----------------
    initial begin
        logic [7:0]    h_vec;
        logic [NC-1:0] h_dest;
        logic [IW-1:0] h_src;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        @(negedge clk);
        check(msg_valid === 1'b0, "R1", "valid after reset", msg_valid, 0);
        rd_check(0,  32'h0400_0000, "R1");
        rd_check(23, 32'h0400_0000, "R1");

        // R2: field placement, truncation of dest, out-of-range index
        wr_entry(5, 32'hFFFF_FFFF);
        rd_check(5, 32'h070F_0FFF, "R2");
        rd_check(26, 32'h0000_0000, "R2");
        wr_entry(5, 32'h0400_0000);

        // R3, R7, R10: edge line in broadcast mode
        wr_entry(3, enc(8'h33, 4'd2, 8'b1010, 0, 0, 0));
        clear_cap();
        step(1); irq_pins[3] = 1;
        @(negedge clk); @(negedge clk);
        check(msg_valid === 1'b0, "R10", "valid one edge after rise", msg_valid, 0);
        @(negedge clk);
        check(msg_valid === 1'b1, "R10", "valid two edges after rise", msg_valid, 1);
        step(5); irq_pins[3] = 0;
        step(4);
        expect_count(1, "R7");
        expect_cap(0, 3, 8'h33, 4'b1010, "R3");
        step(1); irq_pins[3] = 1;
        step(1); irq_pins[3] = 0;
        step(5);
        expect_count(2, "R7");

        // R4: lowest-priority selection with tie and later tpr change
        wr_entry(7, enc(8'h77, 4'd5, 8'b1110, 1, 0, 0));
        set_tpr(0, 1); set_tpr(1, 5); set_tpr(2, 3); set_tpr(3, 3);
        clear_cap();
        step(1); irq_pins[7] = 1;
        step(1); irq_pins[7] = 0;
        step(5);
        expect_cap(0, 7, 8'h77, 4'b0100, "R4");
        set_tpr(3, 0);
        step(1); irq_pins[7] = 1;
        step(1); irq_pins[7] = 0;
        step(5);
        expect_cap(1, 7, 8'h77, 4'b1000, "R4");

        // R5: simultaneous lines, order set by programmed priority
        wr_entry(1,  enc(8'h11, 4'd3, 8'b0001, 0, 0, 0));
        wr_entry(10, enc(8'hA0, 4'd9, 8'b0010, 0, 0, 0));
        wr_entry(20, enc(8'h14, 4'd9, 8'b0100, 0, 0, 0));
        clear_cap();
        step(1); irq_pins[1] = 1; irq_pins[10] = 1; irq_pins[20] = 1;
        step(1); irq_pins[1] = 0; irq_pins[10] = 0; irq_pins[20] = 0;
        step(8);
        expect_count(3, "R5");
        expect_cap(0, 10, 8'hA0, 4'b0010, "R5");
        expect_cap(1, 20, 8'h14, 4'b0100, "R5");
        expect_cap(2, 1,  8'h11, 4'b0001, "R5");

        // R9: back-pressure holds the message
        clear_cap();
        step(1); msg_ready = 0; irq_pins[3] = 1;
        step(1); irq_pins[3] = 0;
        step(5);
        check(msg_valid === 1'b1, "R9", "valid under back-pressure", msg_valid, 1);
        h_vec = msg_vector; h_dest = msg_dest; h_src = msg_src;
        set_tpr(0, 9);
        step(3);
        check(msg_valid === 1'b1, "R9", "valid still held", msg_valid, 1);
        check(msg_vector === h_vec, "R9", "vector held", msg_vector, h_vec);
        check(msg_dest === h_dest, "R9", "dest held", msg_dest, h_dest);
        check(msg_src === h_src, "R9", "src held", msg_src, h_src);
        msg_ready = 1;
        step(3);
        expect_count(1, "R9");
        expect_cap(0, 3, 8'h33, 4'b1010, "R9");

        // R6, R8: level line through mask and end of service
        wr_entry(12, enc(8'hC0, 4'd1, 8'b0001, 0, 1, 1));
        clear_cap();
        step(1); irq_pins[12] = 1;
        step(6);
        expect_count(0, "R6");
        wr_entry(12, enc(8'hC0, 4'd1, 8'b0001, 0, 1, 0));
        step(5);
        expect_count(1, "R6");
        expect_cap(0, 12, 8'hC0, 4'b0001, "R6");
        step(6);
        expect_count(1, "R8");
        do_eoi(12);
        step(5);
        expect_count(2, "R8");
        step(1); irq_pins[12] = 0;
        do_eoi(12);
        step(6);
        expect_count(2, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule